// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block tells a pipelined fetch stage, in the same cycle it presents a branch PC, whether the branch will be taken and which PC to fetch next. A direct-mapped table of tagged entries is addressed by low PC bits. Each entry holds a valid bit, an upper-address tag, the last known jump destination and a small confidence counter. When the entry matches, the counter decides the direction and the stored destination supplies the redirect address. When nothing matches, a fixed rule based on the sign of the branch displacement decides instead. A loop-closing branch jumps backwards, so it is guessed taken even before it has ever been seen.

Once the branch executes, the back end reports the real outcome on a resolve port. That report updates a matching entry or replaces whatever sits at its index. The report also flags a misprediction by comparing the outcome with what the front end had guessed. A parameter selects the counter flavour: two-bit hysteresis, which is the default, or a last-outcome bit.

Top module: `bp_predictor`

## Requirements
- R1: Reset invalidates every entry, so every lookup misses until a resolve has written its index.
- R2: On a miss with a negative displacement (bit OFF_W-1 of lkOffset set), the prediction is taken and predNextPc = lkPc + sign-extended lkOffset.
- R3: On a miss with a zero or positive displacement, the prediction is not taken and predNextPc = lkPc + 4.
- R4: The entry index is lkPc[IDX_W+1:2] and the tag is the bits above it. A resolve that misses allocates the entry: it writes the tag and target, and sets the counter to 2'b10 if taken or 2'b01 if not taken. A lookup of that PC hits from the next cycle on.
- R5: On a hit, counter values 2'b10 and 2'b11 predict taken with predNextPc = stored target. Values 2'b00 and 2'b01 predict not taken with predNextPc = lkPc + 4, whatever the displacement sign.
- R6: A resolve that hits increments the counter when taken and decrements it when not taken, holding at 2'b11 and 2'b00.
- R7: In the default two-bit mode, a single not-taken outcome on a strongly taken entry leaves it predicting taken. A loop branch therefore mispredicts only on its exit iteration.
- R8: A lookup whose index matches a valid entry but whose tag differs is a miss and follows R2/R3. A resolve for that PC replaces the entry.
- R9: Table writes take effect on the clock edge. A lookup in the same cycle as a resolve to the same index sees the old contents.
- R10: mispredict is high while rsValid is high and either rsTaken differs from rsPredTaken, or both are taken and rsTarget differs from rsPredTarget. It is low otherwise.
- R11: With ONE_BIT = 1, each resolve sets the counter to 2'b11 if taken and 2'b00 if not taken. A loop branch then mispredicts both on its exit and on the first iteration of its next run.
- R12: A taken resolve that hits rewrites the stored target with rsTarget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkPc | input | PC_W | PC of the branch being fetched |
| lkOffset | input | OFF_W | Signed branch displacement decoded from the instruction |
| predHit | output | 1 | Lookup matched a valid entry |
| predTaken | output | 1 | Predicted direction |
| predNextPc | output | PC_W | Predicted next fetch PC |
| rsValid | input | 1 | A resolved branch is reported this cycle |
| rsPc | input | PC_W | PC of the resolved branch |
| rsTaken | input | 1 | Actual direction |
| rsTarget | input | PC_W | Actual jump destination |
| rsPredTaken | input | 1 | Direction that had been predicted for it |
| rsPredTarget | input | PC_W | Next PC that had been predicted for it |
| mispredict | output | 1 | Resolved outcome differs from the prediction |

## Verification
A corrupted counter appears on predTaken at the very next lookup of that PC. It is most visible when it crosses the 2'b01/2'b10 boundary, so the walk steps one entry through all four counter values and back. A bad tag or valid bit turns an expected hit into a static-rule guess, or the reverse, on predHit in the cycle after the resolve. A lost target write shows up as a wrong predNextPc as soon as the entry next predicts taken. The loop runs compare the mispredict counts of both counter flavours, which exposes faulty hysteresis only after several iterations.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // Write strobes from control to the table datapath.
  typedef struct packed {
    logic wrEn;    // write the entry at the resolve index
    logic alloc;   // replace the tag (new entry)
    logic tgtEn;   // write the target field
    ctr_t newCtr;  // counter value to store
  } tblStrobe_t;
endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lkPc,
  input  logic [OFF_W-1:0] lkOffset,
  input  logic [PC_W-1:0]  rsPc,
  input  logic [PC_W-1:0]  rsTarget,
  input  tblStrobe_t       stb,
  output logic             lkHit,
  output ctr_t             lkCtr,
  output logic [PC_W-1:0]  lkTarget,
  output logic [PC_W-1:0]  seqPc,
  output logic [PC_W-1:0]  brPc,
  output logic             rsHit,
  output ctr_t             rsCtr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [DEPTH-1:0] validQ;
  logic [TAG_W-1:0] tagQ [DEPTH];
  logic [PC_W-1:0]  tgtQ [DEPTH];
  ctr_t             ctrQ [DEPTH];

  logic [IDX_W-1:0] lkIdx, rsIdx;
  logic [TAG_W-1:0] lkTag, rsTag;
  logic             unusedLowBits;

  assign lkIdx = lkPc[IDX_W+1:2];
  assign rsIdx = rsPc[IDX_W+1:2];
  assign lkTag = lkPc[PC_W-1:IDX_W+2];
  assign rsTag = rsPc[PC_W-1:IDX_W+2];
  assign unusedLowBits = ^{lkPc[1:0], rsPc[1:0]};

  // Read ports: combinational, old contents until the edge.
  assign lkHit    = validQ[lkIdx] && (tagQ[lkIdx] == lkTag);
  assign lkCtr    = ctrQ[lkIdx];
  assign lkTarget = tgtQ[lkIdx];
  assign rsHit    = validQ[rsIdx] && (tagQ[rsIdx] == rsTag);
  assign rsCtr    = ctrQ[rsIdx];

  // Address arithmetic for the fall-through and static paths.
  assign seqPc = lkPc + PC_W'(4);
  assign brPc  = lkPc + {{(PC_W-OFF_W){lkOffset[OFF_W-1]}}, lkOffset};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         validQ <= '0;
    else if (stb.wrEn)  validQ[rsIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      ctrQ[rsIdx] <= stb.newCtr;
      if (stb.alloc) tagQ[rsIdx] <= rsTag;
      if (stb.tgtEn) tgtQ[rsIdx] <= rsTarget;
    end
  end
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter bit ONE_BIT = 1'b0
) (
  input  logic            lkHit,
  input  ctr_t            lkCtr,
  input  logic [PC_W-1:0] lkTarget,
  input  logic [PC_W-1:0] seqPc,
  input  logic [PC_W-1:0] brPc,
  input  logic            lkOffNeg,
  input  logic            rsValid,
  input  logic            rsHit,
  input  ctr_t            rsCtr,
  input  logic            rsTaken,
  input  logic [PC_W-1:0] rsTarget,
  input  logic            rsPredTaken,
  input  logic [PC_W-1:0] rsPredTarget,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  output logic            mispredict,
  output tblStrobe_t      stb
);
  ctr_t nextCtr;

  // Dynamic counter when present, displacement sign otherwise.
  always_comb begin
    predTaken = lkHit ? lkCtr[1] : lkOffNeg;
    if (!predTaken)  predNextPc = seqPc;
    else if (lkHit)  predNextPc = lkTarget;
    else             predNextPc = brPc;
  end

  assign mispredict = rsValid &&
                      ((rsTaken != rsPredTaken) ||
                       (rsTaken && (rsTarget != rsPredTarget)));

  generate
    if (ONE_BIT) begin : gLastOutcome
      assign nextCtr = rsTaken ? CTR_ST : CTR_SNT;
    end else begin : gHysteresis
      always_comb begin
        if (!rsHit)                         nextCtr = rsTaken ? CTR_WT : CTR_WNT;
        else if (rsTaken && rsCtr != CTR_ST)   nextCtr = rsCtr + 2'd1;
        else if (!rsTaken && rsCtr != CTR_SNT) nextCtr = rsCtr - 2'd1;
        else                                nextCtr = rsCtr;
      end
    end
  endgenerate

  always_comb begin
    stb.wrEn   = rsValid;
    stb.alloc  = !rsHit;
    stb.tgtEn  = rsTaken || !rsHit;
    stb.newCtr = nextCtr;
  end
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int OFF_W   = 16,
  parameter int IDX_W   = 4,
  parameter bit ONE_BIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lkPc,
  input  logic [OFF_W-1:0] lkOffset,
  output logic             predHit,
  output logic             predTaken,
  output logic [PC_W-1:0]  predNextPc,
  input  logic             rsValid,
  input  logic [PC_W-1:0]  rsPc,
  input  logic             rsTaken,
  input  logic [PC_W-1:0]  rsTarget,
  input  logic             rsPredTaken,
  input  logic [PC_W-1:0]  rsPredTarget,
  output logic             mispredict
);
  tblStrobe_t      stb;
  ctr_t            lkCtr, rsCtr;
  logic            lkHit, rsHit;
  logic [PC_W-1:0] lkTarget, seqPc, brPc;

  bp_table #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) uTable (
    .clk(clk), .rst_n(rst_n), .lkPc(lkPc), .lkOffset(lkOffset),
    .rsPc(rsPc), .rsTarget(rsTarget), .stb(stb),
    .lkHit(lkHit), .lkCtr(lkCtr), .lkTarget(lkTarget),
    .seqPc(seqPc), .brPc(brPc), .rsHit(rsHit), .rsCtr(rsCtr)
  );

  bp_ctrl #(.PC_W(PC_W), .ONE_BIT(ONE_BIT)) uCtrl (
    .lkHit(lkHit), .lkCtr(lkCtr), .lkTarget(lkTarget),
    .seqPc(seqPc), .brPc(brPc), .lkOffNeg(lkOffset[OFF_W-1]),
    .rsValid(rsValid), .rsHit(rsHit), .rsCtr(rsCtr),
    .rsTaken(rsTaken), .rsTarget(rsTarget),
    .rsPredTaken(rsPredTaken), .rsPredTarget(rsPredTarget),
    .predTaken(predTaken), .predNextPc(predNextPc),
    .mispredict(mispredict), .stb(stb)
  );

  assign predHit = lkHit;
endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  lkPc,
  input logic [OFF_W-1:0] lkOffset,
  input logic             predHit,
  input logic             predTaken,
  input logic [PC_W-1:0]  predNextPc,
  input logic             rsValid,
  input logic [PC_W-1:0]  rsPc,
  input logic             rsTaken,
  input logic             rsPredTaken,
  input logic             mispredict
);
  logic [PC_W-1:0] sextOff;
  assign sextOff = {{(PC_W-OFF_W){lkOffset[OFF_W-1]}}, lkOffset};

  // R1: nothing hits right after reset is released
  a_r1_no_hit_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !predHit);

  // R2: backward miss jumps to PC plus displacement
  a_r2_backward_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!predHit && lkOffset[OFF_W-1]) |-> (predTaken && predNextPc == lkPc + sextOff));

  // R3: forward miss falls through
  a_r3_forward_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!predHit && !lkOffset[OFF_W-1]) |-> (!predTaken && predNextPc == lkPc + PC_W'(4)));

  // R4: a resolved PC hits on the following cycle
  a_r4_alloc_hits: assert property (@(posedge clk) disable iff (!rst_n)
    rsValid |=> ((lkPc != $past(rsPc)) || predHit));

  // R5: a not-taken hit falls through
  a_r5_nt_hit_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (predHit && !predTaken) |-> (predNextPc == lkPc + PC_W'(4)));

  // R10: direction disagreement flags, agreement on not taken does not
  a_r10_dir_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rsValid && rsTaken != rsPredTaken) |-> mispredict);
  a_r10_nt_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsValid || (!rsTaken && !rsPredTaken)) |-> !mispredict);
endmodule

bind bp_predictor bp_predictor_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rst_n(rst_n), .lkPc(lkPc), .lkOffset(lkOffset),
  .predHit(predHit), .predTaken(predTaken), .predNextPc(predNextPc),
  .rsValid(rsValid), .rsPc(rsPc), .rsTaken(rsTaken),
  .rsPredTaken(rsPredTaken), .mispredict(mispredict)
);

// File: tb/bp_predictor_test.sv
`timescale 1ns/1ps
module bp_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lkPc = '0;
  logic [15:0] lkOffset = '0;
  logic        rsValid = 1'b0, rsTaken = 1'b0, rsPredTaken = 1'b0;
  logic [31:0] rsPc = '0, rsTarget = '0, rsPredTarget = '0;
  logic        predHit, predTaken, mispredict;
  logic [31:0] predNextPc;
  logic        predHit1, predTaken1, mispredict1;
  logic [31:0] predNextPc1;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bp_predictor uut (
    .clk(clk), .rst_n(rst_n), .lkPc(lkPc), .lkOffset(lkOffset),
    .predHit(predHit), .predTaken(predTaken), .predNextPc(predNextPc),
    .rsValid(rsValid), .rsPc(rsPc), .rsTaken(rsTaken), .rsTarget(rsTarget),
    .rsPredTaken(rsPredTaken), .rsPredTarget(rsPredTarget), .mispredict(mispredict));

  bp_predictor #(.ONE_BIT(1'b1)) uut1 (
    .clk(clk), .rst_n(rst_n), .lkPc(lkPc), .lkOffset(lkOffset),
    .predHit(predHit1), .predTaken(predTaken1), .predNextPc(predNextPc1),
    .rsValid(rsValid), .rsPc(rsPc), .rsTaken(rsTaken), .rsTarget(rsTarget),
    .rsPredTaken(rsPredTaken), .rsPredTarget(rsPredTarget), .mispredict(mispredict1));

  typedef struct packed {
    logic        rsV;
    logic [31:0] rPc;
    logic        rT;
    logic [31:0] rTgt;
    logic        rPT;
    logic [31:0] rPTgt;
    logic [31:0] lPc;
    logic [15:0] lOff;
    logic        eHit;
    logic        eTaken;
    logic [31:0] eNext;
    logic        eMis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  // Branch A = 0x100 (index 0, tag 4). 0x140 aliases index 0 with tag 5.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 16'hFFF0, 1'b0, 1'b1, 32'hF0,  1'b0, 8'd2},  // R2
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h200, 16'h0008, 1'b0, 1'b0, 32'h204, 1'b0, 8'd3},  // R3
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h204, 16'h0000, 1'b0, 1'b0, 32'h208, 1'b0, 8'd3},  // R3 zero
    '{1'b1, 32'h100, 1'b1, 32'hF0,  1'b1, 32'hF0,  32'h100, 16'hFFF0, 1'b0, 1'b1, 32'hF0,  1'b0, 8'd9},  // R9 old
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 16'hFFF0, 1'b1, 1'b1, 32'hF0,  1'b0, 8'd4},  // R4 ctr10
    '{1'b1, 32'h100, 1'b0, 32'hF0,  1'b1, 32'hF0,  32'h100, 16'hFFF0, 1'b1, 1'b1, 32'hF0,  1'b1, 8'd10}, // R10 dir
    '{1'b1, 32'h100, 1'b0, 32'hF0,  1'b0, 32'h104, 32'h100, 16'hFFF0, 1'b1, 1'b0, 32'h104, 1'b0, 8'd5},  // R5 ctr01
    '{1'b1, 32'h100, 1'b1, 32'hF0,  1'b0, 32'h104, 32'h100, 16'hFFF0, 1'b1, 1'b0, 32'h104, 1'b1, 8'd6},  // R6 ctr00
    '{1'b1, 32'h100, 1'b1, 32'hE0,  1'b0, 32'h104, 32'h100, 16'hFFF0, 1'b1, 1'b0, 32'h104, 1'b1, 8'd6},  // R6 ctr01
    '{1'b1, 32'h100, 1'b1, 32'hE0,  1'b1, 32'hF0,  32'h100, 16'hFFF0, 1'b1, 1'b1, 32'hE0,  1'b1, 8'd12}, // R12 R10 tgt
    '{1'b1, 32'h100, 1'b1, 32'hE0,  1'b1, 32'hE0,  32'h100, 16'hFFF0, 1'b1, 1'b1, 32'hE0,  1'b0, 8'd6},  // R6 ctr11
    '{1'b1, 32'h100, 1'b0, 32'hE0,  1'b1, 32'hE0,  32'h100, 16'hFFF0, 1'b1, 1'b1, 32'hE0,  1'b1, 8'd6},  // R6 sat 11
    '{1'b1, 32'h100, 1'b0, 32'h500, 1'b1, 32'hE0,  32'h100, 16'hFFF0, 1'b1, 1'b1, 32'hE0,  1'b1, 8'd7},  // R7 ctr10
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 16'hFFF0, 1'b1, 1'b0, 32'h104, 1'b0, 8'd6},  // R6 ctr01
    '{1'b1, 32'h140, 1'b0, 32'h160, 1'b0, 32'h160, 32'h140, 16'h0020, 1'b0, 1'b0, 32'h144, 1'b0, 8'd8},  // R8 alias
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h140, 16'h0020, 1'b1, 1'b0, 32'h144, 1'b0, 8'd4},  // R4 alloc nt
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   32'h100, 16'hFFF0, 1'b0, 1'b1, 32'hF0,  1'b0, 8'd8}   // R8 replaced
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearRs();
    rsValid = 1'b0; rsTaken = 1'b0; rsPredTaken = 1'b0;
    rsPc = '0; rsTarget = '0; rsPredTarget = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    int mis2, mis1, mis2Body;
    bit actual;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: fresh reset, a backward branch must miss and use the static rule
    @(negedge clk);
    lkPc = 32'h100; lkOffset = 16'hFFF0; #1;
    check(predHit == 1'b0, "R1", "hit after reset", 64'(predHit), 64'h0);

    // Table walk: inputs driven mid-cycle, outputs checked before the edge.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rsValid = VECS[i].rsV; rsPc = VECS[i].rPc; rsTaken = VECS[i].rT;
      rsTarget = VECS[i].rTgt; rsPredTaken = VECS[i].rPT; rsPredTarget = VECS[i].rPTgt;
      lkPc = VECS[i].lPc; lkOffset = VECS[i].lOff;
      #1;
      check({predHit, predTaken, predNextPc, mispredict} ==
            {VECS[i].eHit, VECS[i].eTaken, VECS[i].eNext, VECS[i].eMis},
            $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d hit/taken/next/mis", i),
            64'({predHit, predTaken, predNextPc, mispredict}),
            64'({VECS[i].eHit, VECS[i].eTaken, VECS[i].eNext, VECS[i].eMis}));
    end
    @(negedge clk); clearRs();

    // R7 / R11: loop branch at 0x3C8 (index 2), two runs of four iterations
    mis2 = 0; mis1 = 0; mis2Body = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int it = 0; it < 4; it++) begin
        @(negedge clk);
        clearRs();
        lkPc = 32'h3C8; lkOffset = 16'hFFE0;
        #1;
        actual = (it != 3);
        if (predTaken != actual) begin
          mis2++;
          if (it != 3) mis2Body++;
        end
        if (predTaken1 != actual) mis1++;
        rsValid = 1'b1; rsPc = 32'h3C8; rsTaken = actual;
        rsTarget = 32'h3A8; rsPredTaken = actual; rsPredTarget = 32'h3A8;
      end
    end
    @(negedge clk); clearRs();
    check(mis2 == 2, "R7", "two-bit loop mispredicts", 64'(mis2), 64'd2);
    check(mis2Body == 0, "R7", "two-bit mispredicts inside loop", 64'(mis2Body), 64'd0);
    check(mis1 == 3, "R11", "one-bit loop mispredicts", 64'(mis1), 64'd3);

    // R11: after a not-taken resolve the one-bit entry predicts not taken
    lkPc = 32'h3C8; lkOffset = 16'hFFE0; #1;
    check(predHit1 && !predTaken1 && predNextPc1 == 32'h3CC, "R11", "one-bit after exit",
          64'({predHit1, predTaken1, predNextPc1}), 64'({1'b1, 1'b0, 32'h3CC}));
    // R5: two-bit entry sits at 2'b10 after one exit, hit taken to stored target
    check(predHit && predTaken && predNextPc == 32'h3A8, "R5", "two-bit after exit",
          64'({predHit, predTaken, predNextPc}), 64'({1'b1, 1'b1, 32'h3A8}));

    // R1: a second reset drops the learned entries
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    lkPc = 32'h140; lkOffset = 16'h0020; #1;
    check(!predHit && !predTaken && predNextPc == 32'h144, "R1", "entry after reset",
          64'({predHit, predTaken, predNextPc}), 64'({1'b0, 1'b0, 32'h144}));
    lkPc = 32'h3C8; lkOffset = 16'hFFE0; #1;
    check(!predHit && predTaken && predNextPc == 32'h3A8, "R1", "loop entry after reset",
          64'({predHit, predTaken, predNextPc}), 64'({1'b0, 1'b1, 32'h3A8}));

    // R10: taken both ways but wrong target is a mispredict; no resolve is not
    @(negedge clk);
    rsValid = 1'b1; rsPc = 32'h400; rsTaken = 1'b1; rsTarget = 32'h800;
    rsPredTaken = 1'b1; rsPredTarget = 32'h804; #1;
    check(mispredict == 1'b1, "R10", "target mismatch", 64'(mispredict), 64'h1);
    rsValid = 1'b0; #1;
    check(mispredict == 1'b0, "R10", "no resolve", 64'(mispredict), 64'h0);
    @(negedge clk); clearRs();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule